// File: doc/BRIEF.md
# Radix-16 Iterative Significand Multiplier

This block multiplies the significands of two finite, nonzero binary floating-point operands. It uses shift-and-add and takes four multiplier bits in each clock. Each operand arrives as its raw biased exponent and fraction field. A subnormal operand, marked by a zero exponent, is first brought to normal form. Each position it has to move beyond the first lowers the shared result exponent by one. The starting exponent is the sum of the two biased exponents minus the bias.

During the iterations, any nonzero bit that leaves the bottom of the accumulator is recorded in a sticky flag. After the last iteration the product is normalized. The block then presents four values:
- a significand with its leading one in the top position,
- the guard bit just below it,
- a sticky bit that is the OR of every lower product bit,
- a signed exponent that may be zero or negative.

A rounding and exception stage downstream consumes these values. This block does neither. Control is a start pulse, a busy level and a one-cycle done pulse.

Top module: `sigmul_r16`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and done are 0, and sig_o, guard_o, sticky_o and exp_o are all zero.
- R2: A start is taken only when the block is idle, meaning busy and done are both 0. Busy is 1 in the next cycle. A start seen while busy or done is high has no effect on the result or on the outputs.
- R3: Done is a single-cycle pulse. It rises exactly ITERS+3 cycles after the clock edge that took the start, where ITERS = ceil((FRAC_W+1)/4), giving 17 cycles at the default width. Busy stays high from the cycle after the start until done rises, and busy is 0 while done is 1.
- R4: For two normal operands, with the hidden one at bit FRAC_W of each significand, exp_o = exp_a + exp_b - BIAS. It is one higher when the exact significand product is 2 or more.
- R5: A subnormal operand (zero exponent, nonzero fraction) is worth fraction x 2^(1-BIAS-FRAC_W). The result exponent is lowered by (FRAC_W - i - 1), where i is the index of the fraction's highest set bit.
- R6: At done, sig_o (FRAC_W+1 bits) has its MSB set and equals the top FRAC_W+1 bits of the exact product, counted from its leading one.
- R7: At done, guard_o equals the exact product bit just below the LSB of sig_o.
- R8: At done, sticky_o is the OR of all exact product bits below the guard bit. This includes bits that left the accumulator during the iterations.
- R9: The outputs change only on the edge that raises done. They then hold their values until the next operation completes.
- R10: When both operands are small, exp_o comes out zero or negative and is given in two's complement over EXP_W+2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply; taken only when idle |
| exp_a | input | EXP_W | Biased exponent of operand A (0 = subnormal) |
| frac_a | input | FRAC_W | Fraction field of operand A |
| exp_b | input | EXP_W | Biased exponent of operand B (0 = subnormal) |
| frac_b | input | FRAC_W | Fraction field of operand B |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| sig_o | output | FRAC_W+1 | Normalized product significand, MSB set |
| guard_o | output | 1 | Product bit just below sig_o |
| sticky_o | output | 1 | OR of all product bits below the guard |
| exp_o | output | EXP_W+2 | Signed result exponent (two's complement) |

## Verification
The bench uses a narrow configuration with 8 fraction bits and 5 exponent bits. It compares every result against a product computed as an integer in the bench, normalized by locating its leading one.

Four groups of operands are swept:
- A full sweep of operand A's fraction, crossed with a strided set of operand B values and varied exponents. This group separates products below 2 from products of 2 or more, so it tests the exponent increment as well as the guard and sticky extraction.
- Every nonzero subnormal fraction for A against normal B. This group exposes any error in the per-shift exponent adjustment.
- Pairs of subnormals. These drive the exponent negative and test the signed representation.
- Directed runs that raise start during an operation and in the done cycle. These show that a start in those cycles is ignored and that the results hold.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;

    typedef enum logic [2:0] {
        SM_IDLE,
        SM_ITER,
        SM_FIX,
        SM_NORM,
        SM_DONE
    } sm_state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int bits_for(input int value);
        return (value <= 1) ? 1 : $clog2(value + 1);
    endfunction

endpackage

// File: rtl/sigmul_unpack.sv
module sigmul_unpack #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int SIG_W  = FRAC_W + 1,
    parameter int ADJ_W  = 7
) (
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [SIG_W-1:0]  sig,
    output logic [ADJ_W-1:0]  adj
);

    always_comb begin
        int lead;
        int shamt;
        lead  = 0;
        shamt = 0;
        sig   = '0;
        adj   = '0;
        if (exp_in != '0) begin
            sig = {1'b1, frac_in};
        end else if (frac_in != '0) begin
            for (int i = 0; i < FRAC_W; i++) begin
                if (frac_in[i]) lead = i;
            end
            shamt = FRAC_W - lead;
            sig   = SIG_W'(frac_in) << shamt;
            adj   = ADJ_W'(shamt - 1);
        end
    end

endmodule

// File: rtl/sigmul_step.sv
module sigmul_step #(
    parameter int ACC_W   = 64,
    parameter int DIGIT_W = 4
) (
    input  logic [ACC_W-1:0]   acc,
    input  logic [ACC_W-1:0]   mcand,
    input  logic [DIGIT_W-1:0] digit,
    output logic [ACC_W-1:0]   acc_next,
    output logic               dropped
);

    logic [ACC_W-1:0] pp [DIGIT_W];

    for (genvar j = 0; j < DIGIT_W; j++) begin : g_pp
        assign pp[j] = digit[j] ? (mcand << j) : '0;
    end

    always_comb begin
        acc_next = acc >> DIGIT_W;
        for (int j = 0; j < DIGIT_W; j++) begin
            acc_next = acc_next + pp[j];
        end
    end

    assign dropped = |acc[DIGIT_W-1:0];

endmodule

// File: rtl/sigmul_extract.sv
module sigmul_extract #(
    parameter int SIG_W = 53,
    parameter int HB    = 60
) (
    input  logic [HB:0]      acc,
    input  logic             sticky_in,
    output logic [SIG_W-1:0] sig,
    output logic             guard,
    output logic             sticky
);

    localparam int GPOS = HB - SIG_W;

    assign sig    = acc[HB:GPOS+1];
    assign guard  = acc[GPOS];
    assign sticky = sticky_in | (|acc[GPOS-1:0]);

endmodule

// File: rtl/sigmul_r16.sv
module sigmul_r16
    import sigmul_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter int BIAS    = 1023,
    parameter int DIGIT_W = 4,
    parameter int PAD     = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [EXP_W-1:0]          exp_a,
    input  logic [FRAC_W-1:0]         frac_a,
    input  logic [EXP_W-1:0]          exp_b,
    input  logic [FRAC_W-1:0]         frac_b,
    output logic                      busy,
    output logic                      done,
    output logic [FRAC_W:0]           sig_o,
    output logic                      guard_o,
    output logic                      sticky_o,
    output logic signed [EXP_W+1:0]   exp_o
);

    localparam int SIG_W     = FRAC_W + 1;
    localparam int ITERS     = ceil_div(SIG_W, DIGIT_W);
    localparam int MIER_W    = ITERS * DIGIT_W;
    localparam int ACC_W     = SIG_W + PAD + DIGIT_W;
    localparam int HB        = 2 * SIG_W + PAD - 1 - DIGIT_W * (ITERS - 1);
    localparam int ADJ_W     = $clog2(SIG_W) + 1;
    localparam int RES_EXP_W = EXP_W + 2;
    localparam int CNT_W     = bits_for(ITERS);

    typedef struct packed {
        logic [ACC_W-1:0]            acc;
        logic [ACC_W-1:0]            mcand;
        logic [MIER_W-1:0]           mier;
        logic                        sticky;
        logic signed [RES_EXP_W-1:0] exp;
        logic [CNT_W-1:0]            cnt;
    } work_t;

    sm_state_t state;
    work_t     w;

    logic [SIG_W-1:0]            sig_a, sig_b;
    logic [ADJ_W-1:0]            adj_a, adj_b;
    logic signed [RES_EXP_W-1:0] exp_init;
    logic [ACC_W-1:0]            acc_step;
    logic                        step_drop;
    logic [SIG_W-1:0]            ex_sig;
    logic                        ex_guard, ex_sticky;

    sigmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SIG_W(SIG_W), .ADJ_W(ADJ_W)) u_unpack_a (
        .exp_in(exp_a), .frac_in(frac_a), .sig(sig_a), .adj(adj_a)
    );

    sigmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SIG_W(SIG_W), .ADJ_W(ADJ_W)) u_unpack_b (
        .exp_in(exp_b), .frac_in(frac_b), .sig(sig_b), .adj(adj_b)
    );

    assign exp_init = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b})
                    - $signed(RES_EXP_W'(BIAS))
                    - $signed({{(RES_EXP_W-ADJ_W){1'b0}}, adj_a})
                    - $signed({{(RES_EXP_W-ADJ_W){1'b0}}, adj_b});

    sigmul_step #(.ACC_W(ACC_W), .DIGIT_W(DIGIT_W)) u_step (
        .acc(w.acc), .mcand(w.mcand), .digit(w.mier[DIGIT_W-1:0]),
        .acc_next(acc_step), .dropped(step_drop)
    );

    sigmul_extract #(.SIG_W(SIG_W), .HB(HB)) u_extract (
        .acc(w.acc[HB:0]), .sticky_in(w.sticky),
        .sig(ex_sig), .guard(ex_guard), .sticky(ex_sticky)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SM_IDLE;
            w        <= '0;
            sig_o    <= '0;
            guard_o  <= 1'b0;
            sticky_o <= 1'b0;
            exp_o    <= '0;
        end else begin
            unique case (state)
                SM_IDLE: begin
                    if (start) begin
                        w.acc    <= '0;
                        w.mcand  <= ACC_W'(sig_a) << PAD;
                        w.mier   <= MIER_W'(sig_b);
                        w.sticky <= 1'b0;
                        w.exp    <= exp_init;
                        w.cnt    <= '0;
                        state    <= SM_ITER;
                    end
                end
                SM_ITER: begin
                    w.acc    <= acc_step;
                    w.sticky <= w.sticky | step_drop;
                    w.mier   <= w.mier >> DIGIT_W;
                    w.cnt    <= w.cnt + 1'b1;
                    if (w.cnt == CNT_W'(ITERS - 1)) state <= SM_FIX;
                end
                SM_FIX: begin
                    if (w.acc[HB]) w.exp <= w.exp + RES_EXP_W'(1);
                    else           w.acc <= w.acc << 1;
                    state <= SM_NORM;
                end
                SM_NORM: begin
                    if (w.acc[HB] || w.acc == '0) begin
                        sig_o    <= ex_sig;
                        guard_o  <= ex_guard;
                        sticky_o <= ex_sticky;
                        exp_o    <= w.exp;
                        state    <= SM_DONE;
                    end else begin
                        w.acc <= w.acc << 1;
                        w.exp <= w.exp - RES_EXP_W'(1);
                    end
                end
                SM_DONE: state <= SM_IDLE;
                default: state <= SM_IDLE;
            endcase
        end
    end

    assign busy = (state == SM_ITER) || (state == SM_FIX) || (state == SM_NORM);
    assign done = (state == SM_DONE);

endmodule

// File: rtl/sigmul_r16_chk.sv
module sigmul_r16_chk
    import sigmul_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter int DIGIT_W = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [FRAC_W:0]         sig_o,
    input logic                    guard_o,
    input logic                    sticky_o,
    input logic signed [EXP_W+1:0] exp_o
);

    localparam int ITERS = ceil_div(FRAC_W + 1, DIGIT_W);
    localparam int LAT   = ITERS + 3;
    localparam int LAT_W = bits_for(LAT + 1);

    logic [LAT_W-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) lat_cnt <= '0;
        else if (start && !busy && !done) lat_cnt <= LAT_W'(1);
        else if (busy) lat_cnt <= lat_cnt + 1'b1;
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> lat_cnt == LAT_W'(LAT)); // R3

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R2

    AST_SIG_NORMAL: assert property (@(posedge clk) disable iff (rst)
        done |-> sig_o[FRAC_W]); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(sig_o) && $stable(guard_o) && $stable(sticky_o) && $stable(exp_o))); // R9

endmodule

bind sigmul_r16 sigmul_r16_chk #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DIGIT_W(DIGIT_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .sig_o(sig_o), .guard_o(guard_o), .sticky_o(sticky_o), .exp_o(exp_o)
);

// File: tb/sigmul_r16_test.sv
module sigmul_r16_test;

    localparam int CLK_PERIOD = 10;
    localparam int EW    = 5;
    localparam int FW    = 8;
    localparam int BIAS  = 15;
    localparam int SW    = FW + 1;
    localparam int ITERS = (SW + 3) / 4;
    localparam int LAT   = ITERS + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [EW-1:0] exp_a = '0, exp_b = '0;
    logic [FW-1:0] frac_a = '0, frac_b = '0;
    logic busy, done, guard_o, sticky_o;
    logic [FW:0] sig_o;
    logic signed [EW+1:0] exp_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sigmul_r16 #(.EXP_W(EW), .FRAC_W(FW), .BIAS(BIAS)) uut (
        .clk(clk), .rst(rst), .start(start),
        .exp_a(exp_a), .frac_a(frac_a), .exp_b(exp_b), .frac_b(frac_b),
        .busy(busy), .done(done), .sig_o(sig_o), .guard_o(guard_o),
        .sticky_o(sticky_o), .exp_o(exp_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input int ea, input int fa, input int eb, input int fb,
                         output int m_sig, output int m_g, output int m_s, output int m_e);
        longint sa, sb, p, q;
        int msb;
        sa  = (ea == 0) ? fa : (fa | (1 << FW));
        sb  = (eb == 0) ? fb : (fb | (1 << FW));
        p   = sa * sb;
        msb = 0;
        for (int i = 0; i < 40; i++) if (p[i]) msb = i;
        q     = p << (2 * SW - msb);
        m_sig = int'((q >> (2 * SW - FW)) & ((1 << SW) - 1));
        m_g   = int'((q >> (2 * SW - SW)) & 1);
        m_s   = ((q & ((64'd1 << SW) - 1)) != 0) ? 1 : 0;
        m_e   = ((ea == 0) ? 1 : ea) + ((eb == 0) ? 1 : eb) - BIAS + msb - 2 * FW;
    endtask

    // interfere: 1 = raise start mid-run with other operands
    task automatic run_op(input int ea, input int fa, input int eb, input int fb,
                          input bit interfere, input string req);
        int cyc, m_sig, m_g, m_s, m_e;
        logic [FW:0] held_sig;
        logic signed [EW+1:0] held_exp;
        model(ea, fa, eb, fb, m_sig, m_g, m_s, m_e);
        @(negedge clk);
        exp_a = EW'(ea); frac_a = FW'(fa); exp_b = EW'(eb); frac_b = FW'(fb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        while (!done && cyc < 100) begin
            if (interfere && cyc == 2) begin
                exp_a = EW'(ea + 1); frac_a = ~FW'(fa); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == LAT, "R3 latency", cyc, LAT);
        check(int'(sig_o) == m_sig, {"R6 significand ", req}, sig_o, m_sig);
        check(int'(guard_o) == m_g, {"R7 guard ", req}, guard_o, m_g);
        check(int'(sticky_o) == m_s, {"R8 sticky ", req}, sticky_o, m_s);
        check(int'(exp_o) == m_e, {"R4 R5 R10 exponent ", req}, exp_o, m_e);
        if (interfere) begin
            held_sig = sig_o;
            held_exp = exp_o;
            exp_a = '0; frac_a = 8'h01; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b0 && done == 1'b0, "R2 start in done cycle ignored", busy, 0);
            check(sig_o == held_sig && exp_o == held_exp, "R9 outputs hold", sig_o, held_sig);
            @(negedge clk);
            check(sig_o == held_sig && busy == 1'b0, "R9 outputs hold idle", sig_o, held_sig);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0, "R1 reset control", busy, 0);
        check(sig_o == 0 && guard_o == 0 && sticky_o == 0 && exp_o == 0, "R1 reset outputs", sig_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && sig_o == 0 && exp_o == 0, "R1 after reset", busy, 0);

        // R4 R6 R7 R8: normal sweep, products above and below 2
        for (int fa = 0; fa < 256; fa++) begin
            for (int fb = 0; fb < 256; fb += 17) begin
                run_op(1 + (fa % 30), fa, 1 + ((fb * 7 + fa) % 30), fb, 1'b0, "R4 normal");
            end
        end
        // R5: every subnormal A
        for (int fa = 1; fa < 256; fa++) begin
            run_op(0, fa, 3 + (fa % 27), 0, 1'b0, "R5 sub a");
            run_op(0, fa, 29, 255, 1'b0, "R5 sub a");
            run_op(20, 85, 0, fa, 1'b0, "R5 sub b");
        end
        // R10: both subnormal, negative exponents
        for (int fa = 1; fa < 256; fa++) begin
            run_op(0, fa, 0, 1, 1'b0, "R10 both sub");
            run_op(0, fa, 0, 255, 1'b0, "R10 both sub");
            run_op(0, fa, 0, 128, 1'b0, "R10 both sub");
        end
        // R2 R9: interference during the run and in the done cycle
        run_op(15, 0, 15, 0, 1'b1, "R2 interfere");
        run_op(30, 255, 30, 255, 1'b1, "R2 interfere");
        run_op(0, 3, 1, 77, 1'b1, "R2 interfere");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule